// File: doc/BRIEF.md
# Completion Payload Byte-Valid Mask Generator

This block works out which byte lanes of a read completion's payload carry real data. Each outstanding read request has a tag. When the request is sent, the request side pulses a strobe with that tag and with the request's first and last byte enables. The block keeps those enables in a table that the tag indexes, and marks the entry live. When a completion descriptor arrives, the block takes its tag, the two low bits of its lower address, its byte count and its Dword count. It then produces one 4-bit byte-valid mask per payload Dword, one mask per clock cycle.

A payload of more than two Dwords always holds one contiguous run of bytes. Its masks are therefore computed from the address and the byte count. A payload of one or two Dwords may have gaps between its valid bytes, so its masks come from the stored enables. When a completion is the last one for its request, the block releases the tag's entry and pulses a free indication.

A four-state sequencer drives the output. **S_IDLE** waits with `cpl_ready` high and moves to **S_HEAD** when it accepts a descriptor. **S_HEAD** sends the first mask. From S_HEAD the sequencer returns to S_IDLE for a one-Dword payload, goes to **S_TAIL** for a two-Dword payload, and goes to **S_BODY** for anything longer. **S_BODY** sends full masks and stays in S_BODY until one interior Dword remains, after which it moves to S_TAIL. **S_TAIL** sends the final mask and returns to S_IDLE.

Top module: `cpl_bytemask_gen`

## Requirements
- R1: After reset, `cpl_ready` is 1, `mask_valid` is 0 and `tag_free` is 0. Every table entry is not live.
- R2: A `req_issue` pulse stores `req_first_be` and `req_last_be` under `req_tag` and marks that entry live. A later pulse on the same tag overwrites the stored enables.
- R3: A completion is accepted on a clock edge where `cpl_valid` and `cpl_ready` are both 1. From the next cycle, exactly N masks (N = `cpl_dword_count`, 1 or more) appear on N consecutive cycles with `mask_valid` high. `mask_first` is set on the first mask and `mask_last` on the last. `cpl_ready` is 0 while the masks are being sent and is 1 again in the cycle after the last mask.
- R4: When N > 2, the first mask is 4'b1111 shifted left by `cpl_addr_lo` and cut to 4 bits. Bit k of a mask means byte lane k.
- R5: When N > 2, every mask between the first and the last is 4'b1111.
- R6: When N > 2, the last mask has bits 0 through d set and the higher bits clear, where d = (`cpl_addr_lo` + byte count − 1) mod 4.
- R7: When N = 1, the single mask is the stored first byte enable, and both `mask_first` and `mask_last` are set.
- R8: When N = 2, the first mask is the stored first byte enable and the second mask is the stored last byte enable.
- R9: `mask_hit` shows whether the tag was live when the completion was accepted. For N ≤ 2 on a tag that is not live, every mask is 4'b0000. For N > 2, the masks do not depend on whether the tag is live.
- R10: A completion is final when ceil((`cpl_addr_lo` + byte count)/4) equals N. A final completion on a live tag makes `tag_free` high, with `tag_free_id` equal to the tag, during the first-mask cycle only. It also leaves the entry not live. A completion that is not final leaves the entry live.
- R11: If a `req_issue` pulse and the acceptance of a completion fall on the same edge with the same tag, the completion uses the entry as it was before that edge. The issue takes priority over any free, so the entry ends live and holds the new enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_issue | input | 1 | One-cycle strobe: a read request was sent |
| req_tag | input | TAG_W | Tag of the request that was sent |
| req_first_be | input | BE_W | First-Dword byte enables of the request |
| req_last_be | input | BE_W | Last-Dword byte enables of the request |
| cpl_valid | input | 1 | A completion descriptor is present |
| cpl_ready | output | 1 | Block can accept a descriptor (state S_IDLE) |
| cpl_tag | input | TAG_W | Completion tag |
| cpl_addr_lo | input | LO_W | Low two bits of the lower address |
| cpl_byte_count | input | BC_W | Remaining byte count of the request |
| cpl_dword_count | input | DW_W | Payload length in Dwords |
| mask_valid | output | 1 | A mask is presented this cycle |
| mask_bytes | output | BE_W | Byte-valid mask for the current payload Dword |
| mask_first | output | 1 | Mask belongs to the first payload Dword |
| mask_last | output | 1 | Mask belongs to the last payload Dword |
| mask_hit | output | 1 | Tag was live when the completion was accepted |
| tag_free | output | 1 | One-cycle pulse: the tag entry was released |
| tag_free_id | output | TAG_W | Tag that was released |

## Verification
The hardest case to reach is a request being issued on the same edge that a final completion for the same tag is accepted. That edge both reads and writes the entry, and both frees it and makes it live again. The bench drives `req_issue` and `cpl_valid` together on chosen tags for this case. It then sends a second short completion to show that the new enables survived. Random traffic keeps tags in a small pool, so short completions often land on entries that were freed, overwritten or never written, and it mixes final and non-final byte counts with all four address offsets.

// File: rtl/cbv_pkg.sv
package cbv_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_HEAD,
        S_BODY,
        S_TAIL
    } seq_state_e;
endpackage

// File: rtl/cbv_be_table.sv
module cbv_be_table #(
    parameter int TAG_W = 6,
    parameter int BE_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [BE_W-1:0]  wr_first,
    input  logic [BE_W-1:0]  wr_last,
    input  logic             clr_en,
    input  logic [TAG_W-1:0] clr_tag,
    input  logic [TAG_W-1:0] rd_tag,
    output logic [BE_W-1:0]  rd_first,
    output logic [BE_W-1:0]  rd_last,
    output logic             rd_live
);
    localparam int DEPTH = 1 << TAG_W;

    logic [BE_W-1:0]  first_q [DEPTH];
    logic [BE_W-1:0]  last_q  [DEPTH];
    logic [DEPTH-1:0] live_q;

    // Live flags: a write in the same cycle wins over a clear (R11)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
        end else begin
            if (clr_en)
                live_q[clr_tag] <= 1'b0;
            if (wr_en)
                live_q[wr_tag] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            first_q[wr_tag] <= wr_first;
            last_q[wr_tag]  <= wr_last;
        end
    end

    assign rd_first = first_q[rd_tag];
    assign rd_last  = last_q[rd_tag];
    assign rd_live  = live_q[rd_tag];

    a_r2_write_sets_live: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> live_q[$past(wr_tag)]);

    a_r10_clear_drops_live: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(wr_en && wr_tag == clr_tag)) |=> !live_q[$past(clr_tag)]);
endmodule

// File: rtl/cbv_mask_calc.sv
module cbv_mask_calc #(
    parameter int BE_W = 4,
    parameter int BC_W = 13,
    parameter int DW_W = 11,
    localparam int LO_W = $clog2(BE_W)
) (
    input  logic [LO_W-1:0] addr_lo,
    input  logic [BC_W-1:0] byte_count,
    input  logic [DW_W-1:0] dword_count,
    input  logic [BE_W-1:0] stored_first,
    input  logic [BE_W-1:0] stored_last,
    input  logic            live,
    output logic [BE_W-1:0] head_mask,
    output logic [BE_W-1:0] tail_mask,
    output logic            is_final
);
    localparam int SPAN_W = BC_W + LO_W + 1;

    logic            is_short;
    logic [SPAN_W-1:0] span;
    logic [SPAN_W-LO_W-1:0] span_dw;
    logic [LO_W-1:0] tail_off;
    logic [BE_W-1:0] head_long;
    logic [BE_W-1:0] tail_long;
    logic [BE_W-1:0] ones;

    always_comb begin
        ones      = {BE_W{1'b1}};
        is_short  = (dword_count <= DW_W'(2));
        // Dwords covered by the remaining bytes, rounded up
        span      = SPAN_W'(addr_lo) + SPAN_W'(byte_count) + SPAN_W'(BE_W - 1);
        span_dw   = span[SPAN_W-1:LO_W];
        is_final  = (span_dw == (SPAN_W-LO_W)'(dword_count));
        tail_off  = addr_lo + byte_count[LO_W-1:0] - LO_W'(1);
        head_long = ones << addr_lo;
        tail_long = ones >> (LO_W'(BE_W - 1) - tail_off);
        if (is_short) begin
            head_mask = live ? stored_first : '0;
            tail_mask = live ? stored_last  : '0;
        end else begin
            head_mask = head_long;
            tail_mask = tail_long;
        end
    end
endmodule

// File: rtl/cbv_seq.sv
module cbv_seq
    import cbv_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int BE_W  = 4,
    parameter int DW_W  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpl_valid,
    input  logic [TAG_W-1:0] cpl_tag,
    input  logic [DW_W-1:0]  cpl_dword_count,
    input  logic [BE_W-1:0]  head_in,
    input  logic [BE_W-1:0]  tail_in,
    input  logic             hit_in,
    input  logic             final_in,
    output logic             cpl_ready,
    output logic             free_en,
    output logic             mask_valid,
    output logic [BE_W-1:0]  mask_bytes,
    output logic             mask_first,
    output logic             mask_last,
    output logic             mask_hit,
    output logic             tag_free,
    output logic [TAG_W-1:0] tag_free_id
);
    seq_state_e state_q, state_d;

    logic             accept;
    logic [BE_W-1:0]  head_q, tail_q;
    logic             hit_q, one_q, free_q;
    logic [DW_W-1:0]  left_q;
    logic [TAG_W-1:0] tag_q;

    assign accept  = cpl_valid && (state_q == S_IDLE);
    assign free_en = accept && final_in && hit_in;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept) state_d = S_HEAD;
            S_HEAD: begin
                if (one_q)
                    state_d = S_IDLE;
                else if (left_q == '0)
                    state_d = S_TAIL;
                else
                    state_d = S_BODY;
            end
            S_BODY: if (left_q == DW_W'(1)) state_d = S_TAIL;
            S_TAIL: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Descriptor capture and interior count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            hit_q  <= 1'b0;
            one_q  <= 1'b0;
            free_q <= 1'b0;
            left_q <= '0;
            tag_q  <= '0;
        end else if (accept) begin
            head_q <= head_in;
            tail_q <= tail_in;
            hit_q  <= hit_in;
            one_q  <= (cpl_dword_count <= DW_W'(1));
            free_q <= final_in && hit_in;
            left_q <= (cpl_dword_count >= DW_W'(2)) ? cpl_dword_count - DW_W'(2) : '0;
            tag_q  <= cpl_tag;
        end else if (state_q == S_BODY) begin
            left_q <= left_q - DW_W'(1);
        end
    end

    // Outputs
    always_comb begin
        cpl_ready   = 1'b0;
        mask_valid  = 1'b0;
        mask_bytes  = '0;
        mask_first  = 1'b0;
        mask_last   = 1'b0;
        mask_hit    = 1'b0;
        tag_free    = 1'b0;
        tag_free_id = tag_q;
        unique case (state_q)
            S_IDLE: cpl_ready = 1'b1;
            S_HEAD: begin
                mask_valid = 1'b1;
                mask_bytes = head_q;
                mask_first = 1'b1;
                mask_last  = one_q;
                mask_hit   = hit_q;
                tag_free   = free_q;
            end
            S_BODY: begin
                mask_valid = 1'b1;
                mask_bytes = {BE_W{1'b1}};
                mask_hit   = hit_q;
            end
            S_TAIL: begin
                mask_valid = 1'b1;
                mask_bytes = tail_q;
                mask_last  = 1'b1;
                mask_hit   = hit_q;
            end
            default: cpl_ready = 1'b0;
        endcase
    end

    a_r3_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_ready |-> !mask_valid);

    a_r3_first_once: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_valid && mask_first) |=> !mask_first);

    a_r3_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_valid && mask_last) |=> cpl_ready);

    a_r3_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_ready) |=> (mask_valid && mask_first));

    a_r5_body_full: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_valid && !mask_first && !mask_last) |-> (mask_bytes == {BE_W{1'b1}}));

    a_r10_free_on_head: assert property (@(posedge clk) disable iff (!rst_n)
        tag_free |-> (mask_valid && mask_first && mask_hit));
endmodule

// File: rtl/cpl_bytemask_gen.sv
module cpl_bytemask_gen #(
    parameter int TAG_W = 6,
    parameter int BE_W  = 4,
    parameter int BC_W  = 13,
    parameter int DW_W  = 11,
    localparam int LO_W = $clog2(BE_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_issue,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [BE_W-1:0]  req_first_be,
    input  logic [BE_W-1:0]  req_last_be,
    input  logic             cpl_valid,
    output logic             cpl_ready,
    input  logic [TAG_W-1:0] cpl_tag,
    input  logic [LO_W-1:0]  cpl_addr_lo,
    input  logic [BC_W-1:0]  cpl_byte_count,
    input  logic [DW_W-1:0]  cpl_dword_count,
    output logic             mask_valid,
    output logic [BE_W-1:0]  mask_bytes,
    output logic             mask_first,
    output logic             mask_last,
    output logic             mask_hit,
    output logic             tag_free,
    output logic [TAG_W-1:0] tag_free_id
);
    logic [BE_W-1:0] tbl_first, tbl_last;
    logic            tbl_live;
    logic [BE_W-1:0] head_mask, tail_mask;
    logic            is_final;
    logic            free_en;

    cbv_be_table #(.TAG_W(TAG_W), .BE_W(BE_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (req_issue),
        .wr_tag   (req_tag),
        .wr_first (req_first_be),
        .wr_last  (req_last_be),
        .clr_en   (free_en),
        .clr_tag  (cpl_tag),
        .rd_tag   (cpl_tag),
        .rd_first (tbl_first),
        .rd_last  (tbl_last),
        .rd_live  (tbl_live)
    );

    cbv_mask_calc #(.BE_W(BE_W), .BC_W(BC_W), .DW_W(DW_W)) u_calc (
        .addr_lo      (cpl_addr_lo),
        .byte_count   (cpl_byte_count),
        .dword_count  (cpl_dword_count),
        .stored_first (tbl_first),
        .stored_last  (tbl_last),
        .live         (tbl_live),
        .head_mask    (head_mask),
        .tail_mask    (tail_mask),
        .is_final     (is_final)
    );

    cbv_seq #(.TAG_W(TAG_W), .BE_W(BE_W), .DW_W(DW_W)) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .cpl_valid       (cpl_valid),
        .cpl_tag         (cpl_tag),
        .cpl_dword_count (cpl_dword_count),
        .head_in         (head_mask),
        .tail_in         (tail_mask),
        .hit_in          (tbl_live),
        .final_in        (is_final),
        .cpl_ready       (cpl_ready),
        .free_en         (free_en),
        .mask_valid      (mask_valid),
        .mask_bytes      (mask_bytes),
        .mask_first      (mask_first),
        .mask_last       (mask_last),
        .mask_hit        (mask_hit),
        .tag_free        (tag_free),
        .tag_free_id     (tag_free_id)
    );

    a_r9_short_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_ready && !tbl_live && cpl_dword_count <= DW_W'(2))
            |=> (mask_bytes == '0 && !mask_hit));
endmodule

// File: tb/tb_cpl_bytemask_gen.sv
module tb_cpl_bytemask_gen;
    localparam int CLK_PERIOD = 10;
    localparam int TAG_W = 6;
    localparam int BE_W  = 4;
    localparam int BC_W  = 13;
    localparam int DW_W  = 11;
    localparam int NTAG  = 1 << TAG_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_issue = 1'b0;
    logic [TAG_W-1:0] req_tag = '0;
    logic [BE_W-1:0]  req_first_be = '0;
    logic [BE_W-1:0]  req_last_be = '0;
    logic             cpl_valid = 1'b0;
    logic             cpl_ready;
    logic [TAG_W-1:0] cpl_tag = '0;
    logic [1:0]       cpl_addr_lo = '0;
    logic [BC_W-1:0]  cpl_byte_count = '0;
    logic [DW_W-1:0]  cpl_dword_count = '0;
    logic             mask_valid;
    logic [BE_W-1:0]  mask_bytes;
    logic             mask_first, mask_last, mask_hit, tag_free;
    logic [TAG_W-1:0] tag_free_id;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [3:0] m_first [NTAG];
    logic [3:0] m_last  [NTAG];
    logic       m_live  [NTAG];

    cpl_bytemask_gen #(.TAG_W(TAG_W), .BE_W(BE_W), .BC_W(BC_W), .DW_W(DW_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_issue(req_issue), .req_tag(req_tag),
        .req_first_be(req_first_be), .req_last_be(req_last_be),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_tag(cpl_tag),
        .cpl_addr_lo(cpl_addr_lo), .cpl_byte_count(cpl_byte_count),
        .cpl_dword_count(cpl_dword_count),
        .mask_valid(mask_valid), .mask_bytes(mask_bytes),
        .mask_first(mask_first), .mask_last(mask_last), .mask_hit(mask_hit),
        .tag_free(tag_free), .tag_free_id(tag_free_id)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<=150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_mask(input int i, input int dw, input int lo,
                                            input int bc, input logic [3:0] fb,
                                            input logic [3:0] lb, input logic live);
        int d;
        if (dw <= 2) begin
            if (!live) return 4'h0;
            return (i == 0) ? fb : lb;
        end
        if (i == 0) return 4'((4'hF << lo) & 4'hF);
        if (i == dw - 1) begin
            d = (lo + bc - 1) % 4;
            return 4'((1 << (d + 1)) - 1);
        end
        return 4'hF;
    endfunction

    task automatic do_issue(input int tag, input logic [3:0] fb, input logic [3:0] lb);
        @(negedge clk);
        req_issue = 1'b1; req_tag = TAG_W'(tag);
        req_first_be = fb; req_last_be = lb;
        @(negedge clk);
        req_issue = 1'b0;
        m_first[tag] = fb; m_last[tag] = lb; m_live[tag] = 1'b1;
    endtask

    // Completion; optionally a request issue to the same tag on the accept edge (R11)
    task automatic do_cpl(input int tag, input int lo, input int bc, input int dw,
                          input logic co_issue, input logic [3:0] nf, input logic [3:0] nl);
        logic [3:0] fb, lb;
        logic live, fin;
        fb = m_first[tag]; lb = m_last[tag]; live = m_live[tag];
        fin = (((lo + bc + 3) / 4) == dw);
        @(negedge clk);
        chk("R3 ready before accept", 32'(cpl_ready), 32'd1);
        cpl_valid = 1'b1; cpl_tag = TAG_W'(tag); cpl_addr_lo = 2'(lo);
        cpl_byte_count = BC_W'(bc); cpl_dword_count = DW_W'(dw);
        if (co_issue) begin
            req_issue = 1'b1; req_tag = TAG_W'(tag);
            req_first_be = nf; req_last_be = nl;
        end
        @(negedge clk);
        cpl_valid = 1'b0; req_issue = 1'b0;
        if (fin && live) m_live[tag] = 1'b0;
        if (co_issue) begin
            m_first[tag] = nf; m_last[tag] = nl; m_live[tag] = 1'b1;
        end
        for (int i = 0; i < dw; i++) begin
            chk("R3 mask_valid", 32'(mask_valid), 32'd1);
            chk("R3 ready low during masks", 32'(cpl_ready), 32'd0);
            chk("R3 first flag", 32'(mask_first), 32'(i == 0));
            chk("R3 last flag", 32'(mask_last), 32'(i == dw - 1));
            if (dw == 1)      chk("R7 single mask", 32'(mask_bytes), 32'(exp_mask(i, dw, lo, bc, fb, lb, live)));
            else if (dw == 2) chk("R8 two-Dword mask", 32'(mask_bytes), 32'(exp_mask(i, dw, lo, bc, fb, lb, live)));
            else if (i == 0)  chk("R4 head mask", 32'(mask_bytes), 32'(exp_mask(i, dw, lo, bc, fb, lb, live)));
            else if (i == dw - 1) chk("R6 tail mask", 32'(mask_bytes), 32'(exp_mask(i, dw, lo, bc, fb, lb, live)));
            else              chk("R5 body mask", 32'(mask_bytes), 32'hF);
            chk("R9 hit flag", 32'(mask_hit), 32'(live));
            if (i == 0) begin
                chk("R10 free pulse", 32'(tag_free), 32'(fin && live));
                if (fin && live) chk("R10 free id", 32'(tag_free_id), 32'(tag));
            end else begin
                chk("R10 free only on head", 32'(tag_free), 32'd0);
            end
            @(negedge clk);
        end
        chk("R3 ready after last", 32'(cpl_ready), 32'd1);
        chk("R3 no mask after last", 32'(mask_valid), 32'd0);
    endtask

    function automatic int pick_bc(input int lo, input int dw, input logic fin);
        if (fin) return dw * 4 - lo - int'($urandom % (4 - lo));
        return dw * 4 - lo + 1 + int'($urandom % 200);
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        for (int t = 0; t < NTAG; t++) begin
            m_first[t] = '0; m_last[t] = '0; m_live[t] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset ready", 32'(cpl_ready), 32'd1);
        chk("R1 reset mask_valid", 32'(mask_valid), 32'd0);
        chk("R1 reset tag_free", 32'(tag_free), 32'd0);
        // R1: unwritten entry reads as not live
        do_cpl(5, 0, 4, 1, 1'b0, 4'h0, 4'h0);

        // R2/R7: stored non-contiguous enable, then overwrite
        do_issue(9, 4'b1001, 4'b0000);
        do_cpl(9, 0, 40, 1, 1'b0, 4'h0, 4'h0);
        do_issue(9, 4'b0110, 4'b0011);
        do_cpl(9, 1, 20, 2, 1'b0, 4'h0, 4'h0);
        // R10: final completion frees, next short one misses (R9)
        do_cpl(9, 1, 7, 2, 1'b0, 4'h0, 4'h0);
        do_cpl(9, 0, 4, 2, 1'b0, 4'h0, 4'h0);
        // R4/R5/R6 directed long cases, each offset
        for (int lo = 0; lo < 4; lo++) begin
            do_cpl(12, lo, 5 * 4 - lo - lo, 5, 1'b0, 4'h0, 4'h0);
        end
        // R11: issue and final completion on the same edge
        do_issue(20, 4'b1100, 4'b0001);
        do_cpl(20, 0, 8, 2, 1'b1, 4'b0101, 4'b1010);
        do_cpl(20, 0, 8, 2, 1'b0, 4'h0, 4'h0);

        // Random traffic on a small tag pool
        for (int n = 0; n < 400; n++) begin
            int tag, lo, dw, bc;
            logic fin;
            tag = int'($urandom % 8);
            if ($urandom % 3 == 0) begin
                do_issue(tag, 4'($urandom), 4'($urandom));
            end else begin
                lo  = int'($urandom % 4);
                dw  = ($urandom % 10 == 0) ? 12 + int'($urandom % 9) : 1 + int'($urandom % 6);
                fin = 1'($urandom % 2);
                bc  = pick_bc(lo, dw, fin);
                do_cpl(tag, lo, bc, dw, 1'($urandom % 8 == 0), 4'($urandom), 4'($urandom));
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule